// File: doc/BRIEF.md
# Integer Execute-Stage Arithmetic-Logic Unit

This block is the combinational arithmetic-logic unit of a five-stage 32-bit integer pipeline. Each cycle the execute stage presents two operands and a 4-bit function code. The block returns one result word in the same cycle. There is no register or state inside it, so the result follows the inputs directly.

The function set covers the base integer operations: add, subtract, the three bitwise operations, signed and unsigned less-than, and the three shifts. It adds three helper operations for the pipeline. Two of them pass either operand straight through. The third sets the result to 1 when the operands are equal.

All function codes from 13 to 15 are unassigned and produce a zero result. The data width is a parameter and defaults to 32 bits. The shift amount is taken from the low log2(width) bits of operand B.

Top module: `alu_core`

## Requirements
- R1: Function code 0 returns op_a + op_b modulo 2^32; there is no carry or overflow output.
- R2: Function code 1 returns op_a - op_b modulo 2^32.
- R3: Function codes 2, 3 and 4 return the bitwise AND, OR and XOR of the operands respectively.
- R4: Function code 5 returns 1 when op_a is less than op_b as two's-complement numbers, otherwise 0; bits 31..1 are always 0.
- R5: Function code 6 returns 1 when op_a is less than op_b as unsigned numbers, otherwise 0; bits 31..1 are always 0.
- R6: Function code 7 shifts op_a left by op_b[4:0] and fills with zeros; op_b[31:5] has no effect.
- R7: Function code 8 shifts op_a right by op_b[4:0] and fills with copies of op_a[31]; op_b[31:5] has no effect.
- R8: Function code 9 shifts op_a right by op_b[4:0] and fills with zeros; op_b[31:5] has no effect.
- R9: Function code 10 returns op_a unchanged, and function code 11 returns op_b unchanged.
- R10: Function code 12 returns 1 when op_a equals op_b in every bit, otherwise 0; bits 31..1 are always 0.
- R11: Function codes 13, 14 and 15 return zero whatever the operands are.
- R12: The result depends only on the present inputs. It changes when an input changes, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand; shifted value for the shift functions |
| op_b | input | 32 | Second operand; its low 5 bits give the shift amount |
| fn_sel | input | 4 | Function code, 0 to 15 |
| result | output | 32 | Result of the selected function |

## Verification
One subtractor produces both the difference and the two less-than bits, so subtract, signed less-than and unsigned less-than all come from the same evaluation. A fault in the carry or sign logic can therefore corrupt one of these results and leave the others correct. To provoke this, the bench holds each operand pair built from sign-boundary and carry-boundary values (0, 1, all-ones, the most-positive and most-negative values and their neighbours) and steps through all sixteen function codes. Every result is compared with a value the bench computes arithmetically. A shift sweep drives every amount with junk in op_b's upper bits, and pseudo-random pairs then cover the rest of the operand space.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_ADD   = 4'd0,
    FN_SUB   = 4'd1,
    FN_AND   = 4'd2,
    FN_OR    = 4'd3,
    FN_XOR   = 4'd4,
    FN_SLT   = 4'd5,
    FN_SLTU  = 4'd6,
    FN_SLL   = 4'd7,
    FN_SRA   = 4'd8,
    FN_SRL   = 4'd9,
    FN_PASSA = 4'd10,
    FN_PASSB = 4'd11,
    FN_SEQ   = 4'd12
  } alu_fn_e;

  // True for codes that name an operation; the rest must give zero.
  function automatic logic fn_is_assigned(input logic [FN_W-1:0] code);
    return code <= FN_SEQ;
  endfunction

  // Signed less-than from the operand sign bits and the difference sign.
  function automatic logic signed_less(input logic a_msb, input logic b_msb,
                                       input logic diff_msb);
    return (a_msb ^ b_msb) ? a_msb : diff_msb;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum,
  output logic [XLEN-1:0] diff,
  output logic            lt_signed,
  output logic            lt_unsigned
);
  import alu_pkg::*;

  logic [XLEN:0] sub_ext;
  logic          borrow_free;

  assign sum         = a + b;
  assign sub_ext     = {1'b0, a} + {1'b0, ~b} + {{XLEN{1'b0}}, 1'b1};
  assign diff        = sub_ext[XLEN-1:0];
  assign borrow_free = sub_ext[XLEN];
  assign lt_unsigned = ~borrow_free;
  assign lt_signed   = signed_less(a[XLEN-1], b[XLEN-1], diff[XLEN-1]);

  always_comb begin
    p_add_inverse_r1: assert (sum - b == a) else $error("sum does not invert");
    p_sub_inverse_r2: assert (diff + b == a) else $error("diff does not invert");
    p_lt_signed_r4: assert (lt_signed == ($signed(a) < $signed(b)))
      else $error("signed compare mismatch");
    p_lt_unsigned_r5: assert (lt_unsigned == (a < b))
      else $error("unsigned compare mismatch");
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] and_v,
  output logic [XLEN-1:0] or_v,
  output logic [XLEN-1:0] xor_v,
  output logic            equal
);

  assign and_v = a & b;
  assign or_v  = a | b;
  assign xor_v = a ^ b;
  assign equal = ~|xor_v;

  always_comb begin
    p_equal_r10: assert (equal == (a == b)) else $error("equality flag wrong");
    p_or_covers_and_r3: assert ((and_v & ~or_v) == '0) else $error("and/or inconsistent");
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a,
  input  logic [SHW-1:0]  amount,
  input  logic            to_left,
  input  logic            arith,
  output logic [XLEN-1:0] shifted
);

  logic [XLEN-1:0] stage [0:SHW];
  logic [XLEN-1:0] a_rev;
  logic [XLEN-1:0] out_rev;
  logic            fill;

  // A left shift is a right shift of the bit-reversed word.
  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      a_rev[i]   = a[XLEN-1-i];
      out_rev[i] = stage[SHW][XLEN-1-i];
    end
  end

  assign fill     = arith & ~to_left & a[XLEN-1];
  assign stage[0] = to_left ? a_rev : a;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amount[k]
      ? {{STEP{fill}}, stage[k][XLEN-1:STEP]}
      : stage[k];
  end

  assign shifted = to_left ? out_rev : stage[SHW];

  always_comb begin
    p_zero_shift_r6: assert (amount != '0 || shifted == a) else $error("zero shift altered value");
    p_sign_fill_r7: assert (!(arith && !to_left) || shifted[XLEN-1] == a[XLEN-1])
      else $error("sign not kept");
    p_zero_fill_r8: assert (to_left || arith || amount == '0 || !shifted[XLEN-1])
      else $error("logical right shift filled ones");
  end

endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]          op_a,
  input  logic [XLEN-1:0]          op_b,
  input  logic [alu_pkg::FN_W-1:0] fn_sel,
  output logic [XLEN-1:0]          result
);
  import alu_pkg::*;

  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] sum_w, diff_w, and_w, or_w, xor_w, shift_w;
  logic            lt_s_w, lt_u_w, eq_w;
  logic            shift_left_w, shift_arith_w;
  logic            fn_known_w;

  alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a(op_a), .b(op_b), .sum(sum_w), .diff(diff_w),
    .lt_signed(lt_s_w), .lt_unsigned(lt_u_w)
  );

  alu_bitwise #(.XLEN(XLEN)) u_bitwise (
    .a(op_a), .b(op_b), .and_v(and_w), .or_v(or_w), .xor_v(xor_w), .equal(eq_w)
  );

  assign shift_left_w  = (fn_sel == FN_SLL);
  assign shift_arith_w = (fn_sel == FN_SRA);

  alu_shifter #(.XLEN(XLEN)) u_shifter (
    .a(op_a), .amount(op_b[SHW-1:0]), .to_left(shift_left_w),
    .arith(shift_arith_w), .shifted(shift_w)
  );

  assign fn_known_w = fn_is_assigned(fn_sel);

  always_comb begin
    unique case (fn_sel)
      FN_ADD:   result = sum_w;
      FN_SUB:   result = diff_w;
      FN_AND:   result = and_w;
      FN_OR:    result = or_w;
      FN_XOR:   result = xor_w;
      FN_SLT:   result = {{(XLEN-1){1'b0}}, lt_s_w};
      FN_SLTU:  result = {{(XLEN-1){1'b0}}, lt_u_w};
      FN_SLL, FN_SRA, FN_SRL: result = shift_w;
      FN_PASSA: result = op_a;
      FN_PASSB: result = op_b;
      FN_SEQ:   result = {{(XLEN-1){1'b0}}, eq_w};
      default:  result = '0;
    endcase
  end

  always_comb begin
    p_unassigned_zero_r11: assert (fn_known_w || result == '0) else $error("unassigned code nonzero");
    p_flag_width_r4: assert (!(fn_sel inside {FN_SLT, FN_SLTU, FN_SEQ}) || result[XLEN-1:1] == '0)
      else $error("compare result has high bits");
    p_eq_vs_diff_r10: assert (eq_w == (diff_w == '0)) else $error("equal disagrees with difference");
  end

endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;

  localparam int XLEN = 32;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [XLEN-1:0] op_a, op_b, result;
  logic [3:0] fn_sel;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_core #(.XLEN(XLEN)) dut (.op_a(op_a), .op_b(op_b), .fn_sel(fn_sel), .result(result));

  function automatic string req_tag(input logic [3:0] f);
    case (f)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      4'd10, 4'd11: return "R9";
      4'd12: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] f);
    int unsigned n;
    longint sa, sb;
    n  = int'(b % 32);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (f)
      4'd0:  return 32'((64'(a) + 64'(b)) % 64'h1_0000_0000);
      4'd1:  return 32'((64'h1_0000_0000 + 64'(a) - 64'(b)) % 64'h1_0000_0000);
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return a ^ b;
      4'd5:  return (sa < sb) ? 32'd1 : 32'd0;
      4'd6:  return (64'(a) < 64'(b)) ? 32'd1 : 32'd0;
      4'd7:  return 32'(64'(a) * (64'd1 << n));
      4'd8:  return 32'(sa / (longint'(1) << n) - ((sa < 0 && (sa % (longint'(1) << n)) != 0) ? 1 : 0));
      4'd9:  return 32'(64'(a) / (64'd1 << n));
      4'd10: return a;
      4'd11: return b;
      4'd12: return (a == b) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h fn=%0d got=%h exp=%h", tag, op_a, op_b, fn_sel, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] f);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; fn_sel = f;
    #5;
    check(req_tag(f), result, model(a, b, f));
  endtask

  function automatic logic [31:0] xorshift(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog expired got=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] corners [10];
    logic [31:0] seed;
    corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                32'h8000_0001, 32'h7FFF_FFFE, 32'hFFFF_FFFE, 32'h0000_001F, 32'hA5A5_5A5A};
    op_a = '0; op_b = '0; fn_sel = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset-state zero inputs", result, 32'd0);

    // Boundary pairs across every function code (R1..R11).
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int f = 0; f < 16; f++)
          apply(corners[i], corners[j], 4'(f));

    // Shift sweep: every amount, upper bits of op_b as junk (R6, R7, R8).
    for (int s = 0; s < 32; s++) begin
      apply(32'h8421_F00D, {27'h5A5_A5A5, 5'(s)}, 4'd7);
      apply(32'h8421_F00D, {27'h7FF_FFFF, 5'(s)}, 4'd8);
      apply(32'h4421_F00D, {27'h5A5_A5A5, 5'(s)}, 4'd8);
      apply(32'hF421_F00D, {27'h123_4567, 5'(s)}, 4'd9);
    end

    // Equality with equal random operands (R10).
    seed = 32'hC0FF_EE11;
    for (int k = 0; k < 50; k++) begin
      seed = xorshift(seed);
      apply(seed, seed, 4'd12);
      apply(seed, seed, 4'd1);
    end

    // Pseudo-random operand pairs through all codes.
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] ra;
      seed = xorshift(seed);
      ra   = seed;
      seed = xorshift(seed);
      for (int f = 0; f < 16; f++) apply(ra, seed, 4'(f));
    end

    // R12: result follows an input change with no clock edge in between.
    @(negedge clk);
    op_a = 32'd40; op_b = 32'd2; fn_sel = 4'd0;
    #2;
    check("R12 combinational add", result, 32'd42);
    op_b = 32'd5;
    #2;
    check("R12 combinational follow op_b", result, 32'd45);
    fn_sel = 4'd13;
    #2;
    check("R12 R11 code change to unassigned", result, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule